// File: doc/BRIEF.md
# Processor Bus Region Router

This block sits between a processor with a 16-bit address bus and the boards on a backplane. It splits the address space into eight 8 KB regions using the top three address bits. Six of these regions are RAM regions, and each one has its own static enable input. One region holds a window of 32 peripheral register slots, and the last region is empty. Each byte cycle produces a one-hot select for exactly one RAM region or one I/O slot, or no select at all. It also drives the registered address, the write byte and a write strobe toward the boards.

A read that selects nothing returns 0xFF. This covers a disabled RAM region, the part of the I/O region above the slot window, the empty region, and a slot that has no device. A write to any of those places is dropped, because no select is raised.

A 16-bit request runs as two byte cycles in big-endian order. The first cycle uses the given address and carries the high byte. The second cycle uses the address plus one, wrapping within 16 bits, and carries the low byte. A busy flag covers the byte cycles, and a one-cycle done pulse returns the read data.

Top module: `mbus_router`

## Requirements
- R1: Address bits [15:13] pick the region. Regions 0, 1, 2, 3, 5 and 6 are RAM and map to `ram_sel`/`ram_en` bits 0 to 5 in that order. An enabled RAM access raises only that one `ram_sel` bit during its byte cycle.
- R2: When the `ram_en` bit of the addressed RAM region is low, no select is raised. A read returns 0xFF, and a write leaves the RAM contents unchanged.
- R3: An address from 0x8000 to 0x801F raises `io_sel` bit addr[4:0], as 8 ports of 4 consecutive slots. Data written to a present slot is read back from it.
- R4: An address from 0x8020 to 0x9FFF, or from 0xE000 to 0xFFFF, raises no select. A read there returns 0xFF, and a write there changes nothing.
- R5: A slot whose bit in `SLOT_PRESENT` is 0 never gets a select. It reads as 0xFF and ignores writes. By default, slots 8 to 15 are absent.
- R6: A byte read returns {8'h00, byte} on `rdata`. A byte write stores `req_wdata[7:0]`.
- R7: A word read returns the byte at addr in `rdata[15:8]` and the byte at addr+1 in `rdata[7:0]`.
- R8: A word write stores `req_wdata[15:8]` at addr and `req_wdata[7:0]` at addr+1.
- R9: The second byte cycle of a word access uses addr+1 modulo 2^16. A word access at 0xFFFF therefore takes its low byte from 0x0000.
- R10: `busy` is high for 1 cycle on a byte access and 2 cycles on a word access, starting the cycle after the request is sampled. `done` is a single-cycle pulse in the cycle right after `busy` falls, and `rdata` is valid while `done` is high. Selects and `bus_we` are low whenever `busy` is low.
- R11: After synchronous reset, `busy`, `done`, `bus_we` and all selects are low, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_en | input | 6 | Static enables for the six RAM regions |
| req_rd | input | 1 | Read request, sampled while idle |
| req_wr | input | 1 | Write request, sampled while idle |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data (byte access uses [7:0]) |
| ram_rdata | input | 8 | Shared read byte from the RAM boards |
| io_rdata | input | 8 | Shared read byte from the selected I/O slot |
| bus_addr | output | 16 | Registered address of the current byte cycle |
| bus_wdata | output | 8 | Write byte of the current byte cycle |
| bus_we | output | 1 | Write strobe for the current byte cycle |
| ram_sel | output | 6 | One-hot RAM region select |
| io_sel | output | 32 | One-hot I/O slot select |
| rdata | output | 16 | Read result, valid with `done` |
| busy | output | 1 | Access in progress |
| done | output | 1 | Completion pulse |

## Verification
The assertions assume three things about the inputs. A request arrives only while `busy` and `done` are low. `req_rd` and `req_wr` are never high together. `ram_en` stays still while an access is in flight. The stimulus meets all three by issuing each access from a task that waits for its done pulse. The task changes the enables only between accesses and raises exactly one strobe per request. Random addresses are biased toward the edges of each region, the 32-slot window and the area above it, and the 0xFFFF wrap point.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int REGION_BITS = 3;
  localparam int IO_REGION   = 4;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FIRST  = 2'd1,
    SQ_SECOND = 2'd2
  } seq_state_t;

  // RAM index -> address region; the I/O region is skipped
  function automatic logic [REGION_BITS-1:0] ram_region(input int idx);
    if (idx < IO_REGION) return REGION_BITS'(idx);
    return REGION_BITS'(idx + 1);
  endfunction

endpackage

// File: rtl/mbus_addr_dec.sv
module mbus_addr_dec
  import mbus_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          N_RAM        = 6,
  parameter int          N_SLOT       = 32,
  parameter logic [31:0] SLOT_PRESENT = 32'hFFFF_00FF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_RAM-1:0]  ram_en,
  output logic [N_RAM-1:0]  ram_hit,
  output logic [N_SLOT-1:0] io_hit
);
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam int LOW_W  = ADDR_W - REGION_BITS;

  logic [REGION_BITS-1:0] region;
  logic                   io_win;

  assign region = addr[ADDR_W-1 -: REGION_BITS];
  assign io_win = (region == REGION_BITS'(IO_REGION)) &&
                  (addr[LOW_W-1:SLOT_W] == '0);

  for (genvar g = 0; g < N_RAM; g++) begin : g_ram
    assign ram_hit[g] = ram_en[g] && (region == ram_region(g));
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    if (SLOT_PRESENT[s]) begin : g_present
      assign io_hit[s] = io_win && (addr[SLOT_W-1:0] == SLOT_W'(s));
    end else begin : g_absent
      assign io_hit[s] = 1'b0;
    end
  end
endmodule

// File: rtl/mbus_word_seq.sv
module mbus_word_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_rd,
  input  logic            req_wr,
  input  logic            req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2*DW-1:0] req_wdata,
  input  logic [DW-1:0]   rbyte,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic            nxt_act,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_we,
  output logic [2*DW-1:0] rdata,
  output logic            busy,
  output logic            done
);
  seq_state_t      state, state_n;
  logic            word_q;
  logic            we_n;
  logic [DW-1:0]   wlo_q, hi_q, wb_n;
  logic            start;

  assign start = (state == SQ_IDLE) && (req_rd || req_wr);
  assign busy  = (state != SQ_IDLE);

  always_comb begin
    state_n  = state;
    nxt_act  = 1'b0;
    nxt_addr = bus_addr;
    we_n     = bus_we;
    wb_n     = bus_wdata;
    unique case (state)
      SQ_IDLE: if (start) begin
        nxt_act  = 1'b1;
        nxt_addr = req_addr;
        we_n     = req_wr;
        wb_n     = req_word ? req_wdata[2*DW-1:DW] : req_wdata[DW-1:0];
        state_n  = SQ_FIRST;
      end
      SQ_FIRST: if (word_q) begin
        nxt_act  = 1'b1;
        nxt_addr = bus_addr + ADDR_W'(1);
        wb_n     = wlo_q;
        state_n  = SQ_SECOND;
      end else begin
        state_n  = SQ_IDLE;
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      word_q    <= 1'b0;
      wlo_q     <= '0;
      hi_q      <= '0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      state     <= state_n;
      bus_addr  <= nxt_addr;
      bus_wdata <= wb_n;
      bus_we    <= nxt_act && we_n;
      done      <= 1'b0;
      if (start) begin
        word_q <= req_word;
        wlo_q  <= req_wdata[DW-1:0];
      end
      if (state == SQ_FIRST) begin
        if (word_q) begin
          hi_q <= rbyte;
        end else begin
          rdata <= {{DW{1'b0}}, rbyte};
          done  <= 1'b1;
        end
      end
      if (state == SQ_SECOND) begin
        rdata <= {hi_q, rbyte};
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbus_router.sv
module mbus_router
  import mbus_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DW           = 8,
  parameter int          N_RAM        = 6,
  parameter int          N_SLOT       = 32,
  parameter logic [31:0] SLOT_PRESENT = 32'hFFFF_00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_RAM-1:0]  ram_en,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2*DW-1:0]   req_wdata,
  input  logic [DW-1:0]     ram_rdata,
  input  logic [DW-1:0]     io_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_we,
  output logic [N_RAM-1:0]  ram_sel,
  output logic [N_SLOT-1:0] io_sel,
  output logic [2*DW-1:0]   rdata,
  output logic              busy,
  output logic              done
);
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_act;
  logic [N_RAM-1:0]  ram_hit;
  logic [N_SLOT-1:0] io_hit;
  logic [DW-1:0]     rbyte;

  mbus_addr_dec #(
    .ADDR_W(ADDR_W), .N_RAM(N_RAM), .N_SLOT(N_SLOT), .SLOT_PRESENT(SLOT_PRESENT)
  ) u_dec (
    .addr(nxt_addr), .ram_en(ram_en), .ram_hit(ram_hit), .io_hit(io_hit)
  );

  // nothing selected -> floating bus reads as all ones
  always_comb begin
    if (|ram_sel)     rbyte = ram_rdata;
    else if (|io_sel) rbyte = io_rdata;
    else              rbyte = {DW{1'b1}};
  end

  mbus_word_seq #(.ADDR_W(ADDR_W), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .req_rd(req_rd), .req_wr(req_wr), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .rbyte(rbyte),
    .nxt_addr(nxt_addr), .nxt_act(nxt_act),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .rdata(rdata), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_sel <= '0;
      io_sel  <= '0;
    end else begin
      ram_sel <= nxt_act ? ram_hit : '0;
      io_sel  <= nxt_act ? io_hit  : '0;
    end
  end
endmodule

module mbus_router_chk #(
  parameter int ADDR_W = 16,
  parameter int N_RAM  = 6,
  parameter int N_SLOT = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [N_RAM-1:0]  ram_en,
  input logic [N_RAM-1:0]  ram_sel,
  input logic [N_SLOT-1:0] io_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              busy,
  input logic              done
);
  AST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_sel, io_sel})); // R1
  AST_EN_GATES_SEL: assert property (@(posedge clk) disable iff (rst)
    (ram_sel & ~ram_en) == '0); // R2
  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (|io_sel) |-> (bus_addr[ADDR_W-1:5] == 11'h400)); // R3
  AST_NO_SEL_TOP: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[ADDR_W-1 -: 3] == 3'd7) |-> (ram_sel == '0 && io_sel == '0)); // R4
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((bus_addr - $past(bus_addr)) == ADDR_W'(1))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ram_sel == '0 && io_sel == '0 && !bus_we)); // R10
endmodule

bind mbus_router mbus_router_chk #(
  .ADDR_W(ADDR_W), .N_RAM(N_RAM), .N_SLOT(N_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .ram_en(ram_en), .ram_sel(ram_sel), .io_sel(io_sel),
  .bus_addr(bus_addr), .bus_we(bus_we), .busy(busy), .done(done)
);

// File: tb/tb_mbus_router.sv
module tb_mbus_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PRES = 32'hFFFF_00FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  ram_en = 6'h3F;
  logic        req_rd = 1'b0, req_wr = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [7:0]  ram_rdata, io_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [5:0]  ram_sel;
  logic [31:0] io_sel;
  logic [15:0] rdata;
  logic        busy, done;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_router #(.SLOT_PRESENT(PRES)) dut (
    .clk(clk), .rst(rst), .ram_en(ram_en), .req_rd(req_rd), .req_wr(req_wr),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .ram_rdata(ram_rdata), .io_rdata(io_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .ram_sel(ram_sel), .io_sel(io_sel),
    .rdata(rdata), .busy(busy), .done(done)
  );

  // board models
  logic [7:0] mem [1024];
  logic [7:0] iom [32];
  logic [7:0] sh_mem [1024];
  logic [7:0] sh_io [32];
  logic [4:0] io_idx;

  function automatic logic [9:0] midx(input logic [15:0] a);
    return {a[15:13], a[6:0]};
  endfunction

  always_comb begin
    io_idx = '0;
    for (int k = 0; k < 32; k++) if (io_sel[k]) io_idx = 5'(k);
  end
  assign ram_rdata = mem[midx(bus_addr)];
  assign io_rdata  = iom[io_idx];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 1024; k++) mem[k] <= 8'h00;
      for (int k = 0; k < 32; k++) iom[k] <= 8'h00;
    end else if (bus_we) begin
      if (|ram_sel) mem[midx(bus_addr)] <= bus_wdata;
      if (|io_sel)  iom[io_idx] <= bus_wdata;
    end
  end

  // expected-value functions
  function automatic int ram_of(input logic [15:0] a);
    int r = int'(a[15:13]);
    if (r == 4 || r == 7) return -1;
    return (r < 4) ? r : r - 1;
  endfunction

  function automatic bit io_ok(input logic [15:0] a);
    return (a[15:5] == 11'h400) && PRES[a[4:0]];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    int ri = ram_of(a);
    if (io_ok(a)) return sh_io[a[4:0]];
    if (ri >= 0 && ram_en[ri]) return sh_mem[midx(a)];
    return 8'hFF;
  endfunction

  function automatic void exp_wr(input logic [15:0] a, input logic [7:0] d);
    int ri = ram_of(a);
    if (io_ok(a)) sh_io[a[4:0]] = d;
    else if (ri >= 0 && ram_en[ri]) sh_mem[midx(a)] = d;
  endfunction

  function automatic logic [37:0] exp_sel(input logic [15:0] a);
    int ri = ram_of(a);
    logic [37:0] s = '0;
    if (io_ok(a)) s[6 + int'(a[4:0])] = 1'b1;
    else if (ri >= 0 && ram_en[ri]) s[ri] = 1'b1;
    return s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [37:0] first_sel;

  task automatic do_op(input bit wr, input bit word, input logic [15:0] a,
                       input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_rd = !wr; req_wr = wr; req_word = word; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_rd = 0; req_wr = 0; req_word = 0;
    lat = 1;
    first_sel = {io_sel, ram_sel};
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata;
  endtask

  // full access with expected-value checks
  task automatic acc(input string req, input bit wr, input bit word,
                     input logic [15:0] a, input logic [15:0] wd);
    logic [15:0] rd, ex;
    int lat;
    logic [37:0] es;
    es = exp_sel(a);
    if (!wr) ex = word ? {exp_rd(a), exp_rd(a + 16'd1)} : {8'h00, exp_rd(a)};
    else begin
      ex = '0;
      if (word) begin exp_wr(a, wd[15:8]); exp_wr(a + 16'd1, wd[7:0]); end
      else exp_wr(a, wd[7:0]);
    end
    do_op(wr, word, a, wd, rd, lat);
    chk({req, " sel"}, 64'(first_sel), 64'(es));
    chk({"R10 latency"}, 64'(lat), word ? 64'd3 : 64'd2);
    if (!wr) chk({req, " rdata"}, 64'(rd), 64'(ex));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 1024; k++) sh_mem[k] = 8'h00;
    for (int k = 0; k < 32; k++) sh_io[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset busy/done/we", {busy, done, bus_we}, 0);
    chk("R11 reset sel", {ram_sel, io_sel}, 0);
    chk("R11 reset rdata", 64'(rdata), 0);

    // R1 / R6: every RAM region, byte write then byte read
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a = {3'(i < 4 ? i : i + 1), 13'h0011};
      acc("R6 wr", 1, 0, a, 16'h00A0 + 16'(i));
      acc("R1 rd", 0, 0, a, 0);
    end
    // R2: disabled region drops write, reads FF
    ram_en = 6'b111011;
    acc("R2 wr disabled", 1, 0, 16'h4011, 16'h0055);
    acc("R2 rd disabled", 0, 0, 16'h4011, 0);
    ram_en = 6'h3F;
    acc("R2 write dropped", 0, 0, 16'h4011, 0);
    // R3: I/O slots
    acc("R3 wr slot5", 1, 0, 16'h8005, 16'h003C);
    acc("R3 rd slot5", 0, 0, 16'h8005, 0);
    acc("R3 wr slot31", 1, 0, 16'h801F, 16'h00C7);
    acc("R3 rd slot31", 0, 0, 16'h801F, 0);
    // R4: above window and top region
    acc("R4 wr 8020", 1, 0, 16'h8020, 16'h0011);
    acc("R4 rd 8020", 0, 0, 16'h8020, 0);
    acc("R4 rd 9FFF", 0, 0, 16'h9FFF, 0);
    acc("R4 wr E123", 1, 0, 16'hE123, 16'h0022);
    acc("R4 rd E123", 0, 0, 16'hE123, 0);
    // R5: absent slot
    acc("R5 wr slot9", 1, 0, 16'h8009, 16'h0077);
    acc("R5 rd slot9", 0, 0, 16'h8009, 0);
    // R7 / R8: word order
    acc("R8 word wr", 1, 1, 16'h2100, 16'hBEEF);
    acc("R8 hi byte", 0, 0, 16'h2100, 0);
    acc("R8 lo byte", 0, 0, 16'h2101, 0);
    acc("R7 word rd", 0, 1, 16'h2100, 0);
    // R9: wrap
    acc("R9 word wr FFFF", 1, 1, 16'hFFFF, 16'h1234);
    acc("R9 lo at 0000", 0, 0, 16'h0000, 0);
    acc("R9 word rd FFFF", 0, 1, 16'hFFFF, 0);
    acc("R9 word rd 7FFF", 0, 1, 16'h7FFF, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  r = 3'($urandom % 8);
      logic [12:0] off;
      logic [15:0] a;
      int pick = $urandom % 10;
      if (pick == 0) off = 13'h1FFF;
      else if (r == 3'd4) off = 13'($urandom % 48);
      else off = 13'($urandom % 128);
      a = {r, off};
      ram_en = 6'($urandom) | 6'b100001;
      acc($urandom % 2 ? "R1 rand" : "R3 rand", 1'($urandom % 2), 1'($urandom % 2),
          a, 16'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule